// File: doc/BRIEF.md
# Tiled Regional Digital Gain

This block scales a raster pixel stream by a digital gain. The picture is cut into a five-by-five grid of tiles whose edges are set by four column edges and four row edges. Each tile holds its own gain, or one common gain can be applied to every pixel instead. The block tracks the column and row of each pixel and picks the gain of the tile that holds it. It multiplies the pixel by that gain and clips the result to the pixel width.

Gains are 4-bit codes `n` that mean `n/4`, so code 1 is 0.25x and code 15 is 3.75x. Writes from a simple register port land in a staging copy. The staging copy moves to the working copy only while frame-valid is low, so a frame never sees a change of gain or tile edges part way through.

Top module: `rg_top`

## Requirements
- R1: While reset is held and right after it is released, `pixOut` is 0 and `outValid`, `outLine` and `outFrame` are low.
- R2: `outValid`, `outLine` and `outFrame` repeat `pixValid`, `lineValid` and `frameValid` exactly two clock cycles later. `pixOut` belongs to the input pixel of the same cycle.
- R3: For a valid pixel `p` with selected gain code `g`, `pixOut = min(1023, (p*g) >> 2)`. When the delayed valid is low, `pixOut` is 0.
- R4: The tile column is the number of column edges (addresses 0..3) that are less than or equal to the pixel's column. The tile row is the number of row edges (addresses 4..7) that are less than or equal to the pixel's row. In per-tile mode the gain is the low 4 bits at address 16 + 5*tileRow + tileColumn.
- R5: The column index is 0 for the first valid pixel after a rising `lineValid` and advances by one for each valid pixel. Cycles inside a line with `pixValid` low do not advance it.
- R6: The row index is 0 for the first line after a rising `frameValid` and advances by one after each falling `lineValid`.
- R7: Bit 0 of address 9 selects the mode: 0 applies the low 4 bits of address 8 to every pixel, and 1 selects per-tile gains. After reset the mode is 0, every gain code is 4 (unity) and every edge is 0.
- R8: A write takes effect only through a transfer that occurs in cycles with `frameValid` low. A write made while `frameValid` is high does not change the output of the rest of that frame, and it applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixIn | input | 10 | Input pixel |
| pixValid | input | 1 | Input pixel is valid |
| lineValid | input | 1 | Line active |
| frameValid | input | 1 | Frame active |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register write address |
| wrData | input | 10 | Register write data |
| pixOut | output | 10 | Scaled and clipped pixel |
| outValid | output | 1 | Delayed pixel valid |
| outLine | output | 1 | Delayed line active |
| outFrame | output | 1 | Delayed frame active |

## Verification
A pixel presented in cycle t is registered with its tile gain at the end of t and scaled at the end of t+1, so its result and sidebands are due in cycle t+2. The bench pushes every expected value into its own two-stage delay line at each rising edge and compares the third stage against the outputs at the falling edge. In this way every cycle is checked against the cycle it belongs to. A write made mid-frame is modelled as taking effect only at the next frame start, so the frames on either side of it are checked with the old and new gains.

// File: rtl/rg_pkg.sv
package rg_pkg;
  parameter int PIX_W     = 10;
  parameter int COORD_W   = 10;
  parameter int GAIN_W    = 4;
  parameter int GAIN_FRAC = 2;
  parameter int TILES_X   = 5;
  parameter int TILES_Y   = 5;
  parameter int ADDR_W    = 6;

  localparam int NUM_TILES  = TILES_X * TILES_Y;
  localparam int NUM_BX     = TILES_X - 1;
  localparam int NUM_BY     = TILES_Y - 1;
  localparam int TILE_IDX_W = $clog2(NUM_TILES);
  localparam int ADDR_XB    = 0;
  localparam int ADDR_YB    = ADDR_XB + NUM_BX;
  localparam int ADDR_GLOB  = ADDR_YB + NUM_BY;
  localparam int ADDR_MODE  = ADDR_GLOB + 1;
  localparam int ADDR_TILE  = 16;
  localparam int UNITY      = 1 << GAIN_FRAC;

  typedef struct packed {
    logic              valid;
    logic              line;
    logic              frame;
    logic [GAIN_W-1:0] gain;
    logic [PIX_W-1:0]  pix;
  } stage_t;
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic               pixValid,
  input  logic               lineValid,
  input  logic               frameValid,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [COORD_W-1:0] wrData,
  output stage_t             stage
);
  localparam int TC_W = $clog2(TILES_X + 1);
  localparam int TR_W = $clog2(TILES_Y + 1);

  logic lvPrev, fvPrev;
  logic lvRise, lvFall, fvRise;
  logic [COORD_W-1:0] colCnt, rowCnt, curCol, curRow;

  logic [COORD_W-1:0] shX [NUM_BX];
  logic [COORD_W-1:0] shY [NUM_BY];
  logic [COORD_W-1:0] actX [NUM_BX];
  logic [COORD_W-1:0] actY [NUM_BY];
  logic [GAIN_W-1:0]  shGain [NUM_TILES];
  logic [GAIN_W-1:0]  actGain [NUM_TILES];
  logic [GAIN_W-1:0]  shGlob, actGlob;
  logic               shMode, actMode;

  logic [TC_W-1:0]       tileCol;
  logic [TR_W-1:0]       tileRow;
  logic [TILE_IDX_W-1:0] tileIdx;
  logic [GAIN_W-1:0]     gainSel;

  // staging registers, written from the port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BX; k++) shX[k] <= '0;
      for (int k = 0; k < NUM_BY; k++) shY[k] <= '0;
      for (int k = 0; k < NUM_TILES; k++) shGain[k] <= GAIN_W'(UNITY);
      shGlob <= GAIN_W'(UNITY);
      shMode <= 1'b0;
    end else if (wrEn) begin
      for (int k = 0; k < NUM_BX; k++)
        if (wrAddr == ADDR_W'(ADDR_XB + k)) shX[k] <= wrData;
      for (int k = 0; k < NUM_BY; k++)
        if (wrAddr == ADDR_W'(ADDR_YB + k)) shY[k] <= wrData;
      for (int k = 0; k < NUM_TILES; k++)
        if (wrAddr == ADDR_W'(ADDR_TILE + k)) shGain[k] <= wrData[GAIN_W-1:0];
      if (wrAddr == ADDR_W'(ADDR_GLOB)) shGlob <= wrData[GAIN_W-1:0];
      if (wrAddr == ADDR_W'(ADDR_MODE)) shMode <= wrData[0];
    end
  end

  // working set follows staging only between frames
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_BX; k++) actX[k] <= '0;
      for (int k = 0; k < NUM_BY; k++) actY[k] <= '0;
      for (int k = 0; k < NUM_TILES; k++) actGain[k] <= GAIN_W'(UNITY);
      actGlob <= GAIN_W'(UNITY);
      actMode <= 1'b0;
    end else if (!frameValid) begin
      actX    <= shX;
      actY    <= shY;
      actGain <= shGain;
      actGlob <= shGlob;
      actMode <= shMode;
    end
  end

  // raster position
  assign lvRise = lineValid & ~lvPrev;
  assign lvFall = ~lineValid & lvPrev;
  assign fvRise = frameValid & ~fvPrev;
  assign curCol = lvRise ? '0 : colCnt;
  assign curRow = fvRise ? '0 : rowCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvPrev <= 1'b0;
      fvPrev <= 1'b0;
      colCnt <= '0;
      rowCnt <= '0;
    end else begin
      lvPrev <= lineValid;
      fvPrev <= frameValid;
      colCnt <= curCol + COORD_W'(pixValid & lineValid);
      rowCnt <= lvFall ? curRow + 1'b1 : curRow;
    end
  end

  // tile decode: count the edges at or below the position
  always_comb begin
    tileCol = '0;
    for (int k = 0; k < NUM_BX; k++)
      if (actX[k] <= curCol) tileCol = tileCol + 1'b1;
    tileRow = '0;
    for (int k = 0; k < NUM_BY; k++)
      if (actY[k] <= curRow) tileRow = tileRow + 1'b1;
    tileIdx = TILE_IDX_W'(tileRow) * TILE_IDX_W'(TILES_X) + TILE_IDX_W'(tileCol);
    gainSel = actMode ? actGain[tileIdx] : actGlob;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else begin
      stage.valid <= pixValid;
      stage.line  <= lineValid;
      stage.frame <= frameValid;
      stage.gain  <= gainSel;
      stage.pix   <= pixIn;
    end
  end

  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frameValid && $past(frameValid)) |-> ($stable(actGlob) && $stable(actMode)));

  p_col_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lineValid) && $past(lvPrev) && !$past(pixValid)) |-> (colCnt == $past(colCnt)));

  p_row_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frameValid && !fvPrev && !lvPrev) |-> (rowCnt == '0));
endmodule

// File: rtl/rg_datapath.sv
module rg_datapath
  import rg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  stage_t           stIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             outValid,
  output logic             outLine,
  output logic             outFrame
);
  localparam int PROD_W   = PIX_W + GAIN_W;
  localparam int SCALED_W = PROD_W - GAIN_FRAC;

  logic [PROD_W-1:0]   prod;
  logic [SCALED_W-1:0] scaled;
  logic                over;
  logic [PIX_W-1:0]    clipped;

  assign prod    = {{GAIN_W{1'b0}}, stIn.pix} * {{PIX_W{1'b0}}, stIn.gain};
  assign scaled  = prod[PROD_W-1:GAIN_FRAC];
  assign over    = |scaled[SCALED_W-1:PIX_W];
  assign clipped = over ? '1 : scaled[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixOut   <= '0;
      outValid <= 1'b0;
      outLine  <= 1'b0;
      outFrame <= 1'b0;
    end else begin
      pixOut   <= stIn.valid ? clipped : '0;
      outValid <= stIn.valid;
      outLine  <= stIn.line;
      outFrame <= stIn.frame;
    end
  end

  p_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stIn.valid) && $past(stIn.gain) == GAIN_W'(UNITY)) |-> (pixOut == $past(stIn.pix)));
endmodule

// File: rtl/rg_top.sv
module rg_top
  import rg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic               pixValid,
  input  logic               lineValid,
  input  logic               frameValid,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [COORD_W-1:0] wrData,
  output logic [PIX_W-1:0]   pixOut,
  output logic               outValid,
  output logic               outLine,
  output logic               outFrame
);
  stage_t stageBus;

  rg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixIn(pixIn), .pixValid(pixValid),
    .lineValid(lineValid), .frameValid(frameValid), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .stage(stageBus)
  );

  rg_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stIn(stageBus), .pixOut(pixOut),
    .outValid(outValid), .outLine(outLine), .outFrame(outFrame)
  );

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid == $past(pixValid, 2)) && (outFrame == $past(frameValid, 2)));
endmodule

// File: tb/sim_rg_top.sv
module sim_rg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pixIn = '0;
  logic       pixValid = 1'b0, lineValid = 1'b0, frameValid = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic [9:0] pixOut;
  logic       outValid, outLine, outFrame;

  rg_top u0 (
    .clk(clk), .rst_n(rst_n), .pixIn(pixIn), .pixValid(pixValid),
    .lineValid(lineValid), .frameValid(frameValid), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pixOut(pixOut),
    .outValid(outValid), .outLine(outLine), .outFrame(outFrame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit chkOn = 0, done = 0;
  bit curFv = 0;
  string curTag = "R1";

  // bench model: staging and working copies
  int sX[4], sY[4], sGain[25], sGlob = 4, sMode = 0;
  int aX[4], aY[4], aGain[25], aGlob = 4, aMode = 0;

  // expected delay line
  logic cV = 0, cL = 0, cF = 0;
  logic [9:0] cD = '0;
  string cTag = "R2";
  logic e1V = 0, e1L = 0, e1F = 0, e2V = 0, e2L = 0, e2F = 0;
  logic [9:0] e1D = '0, e2D = '0;
  string e1Tag = "R2", e2Tag = "R2";

  always @(posedge clk) begin
    e1V <= cV; e1L <= cL; e1F <= cF; e1D <= cD; e1Tag <= cTag;
    e2V <= e1V; e2L <= e1L; e2F <= e1F; e2D <= e1D; e2Tag <= e1Tag;
  end

  always @(negedge clk) begin
    if (chkOn && !done) begin
      nChecks++;
      if (outValid !== e2V || outLine !== e2L || outFrame !== e2F || pixOut !== e2D) begin
        nFail++;
        $display("FAIL %s: got v=%0b l=%0b f=%0b d=%0d, expected v=%0b l=%0b f=%0b d=%0d",
                 e2Tag, outValid, outLine, outFrame, pixOut, e2V, e2L, e2F, e2D);
      end
    end
  end

  function automatic int gainOf(int r, int c);
    int tx, ty;
    tx = 0; ty = 0;
    for (int k = 0; k < 4; k++) begin
      if (aX[k] <= c) tx++;
      if (aY[k] <= r) ty++;
    end
    return (aMode != 0) ? aGain[ty*5 + tx] : aGlob;
  endfunction

  function automatic logic [9:0] scaleOf(int p, int g);
    int v;
    v = (p * g) >>> 2;
    if (v > 1023) v = 1023;
    return 10'(v);
  endfunction

  task automatic drive(bit pv, bit lv, bit fv, int pix, int r, int c);
    @(negedge clk);
    wrEn = 1'b0;
    pixValid = pv; lineValid = lv; frameValid = fv; pixIn = 10'(pix);
    cV = pv; cL = lv; cF = fv; cTag = curTag;
    cD = pv ? scaleOf(pix, gainOf(r, c)) : 10'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, curFv, 0, 0, 0);
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    pixValid = 0; lineValid = 0; frameValid = curFv; pixIn = '0;
    wrEn = 1'b1; wrAddr = 6'(addr); wrData = 10'(data);
    cV = 0; cL = 0; cF = curFv; cD = '0; cTag = curTag;
    if (addr < 4) sX[addr] = data;
    else if (addr < 8) sY[addr-4] = data;
    else if (addr == 8) sGlob = data & 15;
    else if (addr == 9) sMode = data & 1;
    else if (addr >= 16 && addr < 41) sGain[addr-16] = data & 15;
  endtask

  task automatic startFrame();
    curFv = 0;
    idle(3);
    aX = sX; aY = sY; aGain = sGain; aGlob = sGlob; aMode = sMode;
    curFv = 1;
    idle(2);
  endtask

  task automatic endFrame();
    curFv = 0;
    idle(4);
  endtask

  task automatic line(int r, int n, int gap, bit sweep);
    int c, k, pix;
    c = 0; k = 0;
    while (c < n) begin
      if (gap > 0 && (k % gap) == gap - 1) drive(0, 1, 1, 0, r, c);
      else begin
        pix = sweep ? ((r*n + c) % 1024) : ((r*37 + c*11 + 5) % 1024);
        drive(1, 1, 1, pix, r, c);
        c++;
      end
      k++;
    end
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 0, 0);
  endtask

  task automatic frame(int rows, int cols, int gap, bit sweep);
    startFrame();
    for (int r = 0; r < rows; r++) line(r, cols, gap, sweep);
    endFrame();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin sX[k] = 0; sY[k] = 0; aX[k] = 0; aY[k] = 0; end
    for (int k = 0; k < 25; k++) begin sGain[k] = 4; aGain[k] = 4; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nChecks++;
    if (pixOut !== 10'd0 || outValid !== 1'b0 || outLine !== 1'b0 || outFrame !== 1'b0) begin
      nFail++;
      $display("FAIL R1: got d=%0d v=%0b l=%0b f=%0b, expected d=0 v=0 l=0 f=0",
               pixOut, outValid, outLine, outFrame);
    end
    chkOn = 1;

    // defaults: global mode, unity gain
    curTag = "R7 R2 default unity";
    frame(4, 6, 0, 0);

    // per-tile mode with programmed edges
    curTag = "R4 setup";
    wr(0, 2); wr(1, 4); wr(2, 6); wr(3, 9);
    wr(4, 1); wr(5, 3); wr(6, 5); wr(7, 8);
    for (int k = 0; k < 25; k++) wr(16 + k, (k % 15) + 1);
    wr(9, 1);
    curTag = "R4 R5 R6 tiles with gaps";
    frame(10, 12, 5, 0);
    curTag = "R4 R6 tiles dense";
    frame(10, 12, 0, 0);

    // global mode sweeps of all pixel codes
    curTag = "R7 R3 setup";
    wr(9, 0); wr(8, 15);
    curTag = "R3 R7 saturation gain 15";
    frame(8, 128, 0, 1);
    wr(8, 1);
    curTag = "R3 gain 1";
    frame(8, 128, 7, 1);

    // staging: mid-frame write must wait for the next frame
    wr(8, 8);
    curTag = "R8 before write";
    startFrame();
    line(0, 20, 0, 0);
    line(1, 20, 0, 0);
    wr(8, 2);
    curTag = "R8 after mid-frame write";
    line(2, 20, 0, 0);
    line(3, 20, 0, 0);
    endFrame();
    curTag = "R8 next frame";
    frame(3, 20, 0, 0);

    idle(4);
    finishRun();
  end
endmodule